// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block drives one pulse-width-modulated output from an up/down counter that advances on a single-cycle `tick` strobe. Software reaches it through a small write port with four targets: period, duty, counter and control (enable, start polarity, alignment). The counter runs from zero up to the period and wraps (left-aligned), or runs up to the period and back down to zero (center-aligned). The output sits at the start level while the count is below the active duty value and at the opposite level otherwise.

Period, duty, polarity and alignment each have a buffer copy and an active copy, so a waveform in flight is never changed partway through. While the channel runs, writes go to the buffers only. The buffers move into the active copies at the end of a period, on any counter write, or when the channel is switched off. While the channel is stopped, writes reach the active copies at once. A counter write restarts the waveform at count zero, so a new setting can be applied immediately.

Top module: `pwm_channel`

## Requirements
- R1: After reset the channel is disabled, period, duty and counter are zero, polarity is 0, alignment is left, and `pwm_out` is 0.
- R2: The output is at the start level (polarity 0 = low, 1 = high) while the count is below the active duty value and at the opposite level otherwise. A duty above the period keeps the start level all period, and a duty of 0 keeps the opposite level.
- R3: With alignment 0 (left), the count runs 0 to period-1 and then returns to 0, so a period lasts `period` ticks with `duty` ticks at the start level.
- R4: With alignment 1 (center), the count runs 0 up to period and back down to 1, and the period ends when it reaches 0. A period lasts 2×`period` ticks, with 2×`duty`-1 of them at the start level (1 ≤ duty ≤ period).
- R5: The count changes only on clock edges where `tick` is 1 and the channel is enabled. When disabled, the count holds.
- R6: While enabled, a write to period (`wr_sel`=0) or duty (`wr_sel`=1) changes only the buffer. The current period completes with the old values, and the new values apply from the next period.
- R7: While disabled, a period or duty write takes effect on the output in the next cycle.
- R8: A write of any data to the counter (`wr_sel`=2) sets the count to 0 with up-counting and loads all active values from the buffers. The new waveform starts in the next cycle.
- R9: A control write (`wr_sel`=3, bit 0 enable, bit 1 polarity, bit 2 alignment) that clears the enable bit copies the buffered period and duty into the active copies.
- R10: With an active period of 0, the counter stays at 0 and the output stays at the start level.
- R11: A polarity or alignment change written while enabled applies at the next period end or counter write. One written while disabled applies at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe from the selected clock source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 counter, 3 control |
| wr_data | input | CNT_W | Write data; for control, bit 0 enable, bit 1 polarity, bit 2 center |
| pwm_out | output | 1 | PWM output |

## Verification
The waveform is checked cycle by cycle against expected level sequences for several cases: left-aligned with a mid duty, center-aligned, duty 0, duty above the period and period 0. Together these separate the wrap point, the turning point and the compare boundary. Runs with a tick on every second or third cycle show whether the count really waits for the strobe. Further runs change period and polarity partway through a period, change buffers and then restart, or change duty and then disable. These separate a change applied at the boundary from one leaked early, and show that a restart or a disable applies the buffered values.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_DUTY   = 2'd1,
      SEL_COUNT  = 2'd2,
      SEL_CTRL   = 2'd3
   } pwm_sel_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_POL_BIT = 1;
   localparam int CTRL_CEN_BIT = 2;
   localparam int CTRL_MIN_W   = CTRL_CEN_BIT + 1;

   typedef struct packed {
      logic center;
      logic pol;
   } pwm_shape_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [W-1:0]  wr_data,
   input  logic          period_end,
   output logic          enable,
   output logic [W-1:0]  per_act,
   output logic [W-1:0]  duty_act,
   output pwm_shape_t    shape_act,
   output logic          restart,
   output logic          load_evt
);

   logic [W-1:0] per_buf;
   logic [W-1:0] duty_buf;
   pwm_shape_t   shape_buf;
   pwm_shape_t   shape_new;
   logic         wr_per;
   logic         wr_duty;
   logic         wr_ctl;
   logic         disable_evt;
   logic         direct_ctl;

   always_comb begin
      wr_per      = wr_en && (wr_sel == SEL_PERIOD);
      wr_duty     = wr_en && (wr_sel == SEL_DUTY);
      wr_ctl      = wr_en && (wr_sel == SEL_CTRL);
      restart     = wr_en && (wr_sel == SEL_COUNT);
      shape_new   = '{center: wr_data[CTRL_CEN_BIT], pol: wr_data[CTRL_POL_BIT]};
      disable_evt = wr_ctl && enable && !wr_data[CTRL_EN_BIT];
      direct_ctl  = wr_ctl && (!enable || !wr_data[CTRL_EN_BIT]);
      load_evt    = period_end || restart || disable_evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable    <= 1'b0;
         per_buf   <= '0;
         duty_buf  <= '0;
         shape_buf <= '0;
      end else begin
         if (wr_per)  per_buf  <= wr_data;
         if (wr_duty) duty_buf <= wr_data;
         if (wr_ctl) begin
            enable    <= wr_data[CTRL_EN_BIT];
            shape_buf <= shape_new;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_act   <= '0;
         duty_act  <= '0;
         shape_act <= '0;
      end else begin
         if (wr_per && !enable)       per_act <= wr_data;
         else if (load_evt)           per_act <= per_buf;

         if (wr_duty && !enable)      duty_act <= wr_data;
         else if (load_evt)           duty_act <= duty_buf;

         if (direct_ctl)              shape_act <= shape_new;
         else if (load_evt)           shape_act <= shape_buf;
      end
   end

endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
   parameter int W         = 8,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          restart,
   input  logic [W-1:0]  per_act,
   input  logic          center_req,
   output logic [W-1:0]  cnt,
   output logic          period_end
);

   localparam int WX = W + 1;

   logic          center;
   logic          down;
   logic          step;
   logic          idle;
   logic [WX-1:0] up_next;
   logic          left_end;
   logic          turn;
   logic          dec;
   logic          ctr_end;
   logic          end_hit;
   logic [W-1:0]  cnt_n;
   logic          down_n;

   generate
      if (CENTER_EN) begin : g_center
         assign center = center_req;
      end else begin : g_left_only
         assign center = 1'b0;
      end
   endgenerate

   always_comb begin
      step     = run && tick && !restart;
      idle     = (per_act == '0);
      up_next  = {1'b0, cnt} + WX'(1);
      left_end = (up_next >= {1'b0, per_act});
      turn     = !down && (cnt >= per_act);
      dec      = down || turn;
      ctr_end  = dec && (cnt <= W'(1));
      end_hit  = idle || (center ? ctr_end : left_end);
      period_end = step && end_hit;
      if (end_hit) begin
         cnt_n  = '0;
         down_n = 1'b0;
      end else if (center && dec) begin
         cnt_n  = cnt - W'(1);
         down_n = 1'b1;
      end else begin
         cnt_n  = up_next[W-1:0];
         down_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt  <= '0;
         down <= 1'b0;
      end else if (step) begin
         cnt  <= cnt_n;
         down <= down_n;
      end
   end

endmodule

// File: rtl/pwm_chan_outstage.sv
module pwm_chan_outstage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  cnt,
   input  logic [W-1:0]  per_act,
   input  logic [W-1:0]  duty_act,
   input  logic          pol,
   output logic          level
);

   logic start_phase;
   logic lvl_c;

   always_comb begin
      start_phase = (per_act == '0) || (cnt < duty_act);
      lvl_c       = start_phase ? pol : !pol;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) level <= 1'b0;
            else        level <= lvl_c;
         end
      end else begin : g_comb
         assign level = lvl_c;
      end
   endgenerate

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit CENTER_EN = 1'b1,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out
);

   generate
      if (CNT_W < CTRL_MIN_W || CNT_W > 16) begin : g_bad_width
         $error("pwm_channel: CNT_W out of range");
      end
   endgenerate

   logic             enable;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] duty_act;
   pwm_shape_t       shape_act;
   logic             restart;
   logic             load_evt;
   logic [CNT_W-1:0] cnt;
   logic             period_end;

   pwm_chan_regs #(.W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .period_end (period_end),
      .enable     (enable),
      .per_act    (per_act),
      .duty_act   (duty_act),
      .shape_act  (shape_act),
      .restart    (restart),
      .load_evt   (load_evt)
   );

   pwm_chan_counter #(.W(CNT_W), .CENTER_EN(CENTER_EN)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (enable),
      .tick       (tick),
      .restart    (restart),
      .per_act    (per_act),
      .center_req (shape_act.center),
      .cnt        (cnt),
      .period_end (period_end)
   );

   pwm_chan_outstage #(.W(CNT_W), .REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .per_act  (per_act),
      .duty_act (duty_act),
      .pol      (shape_act.pol),
      .level    (pwm_out)
   );

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
   parameter int W = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          wr_en,
   input logic [1:0]    wr_sel,
   input logic          enable,
   input logic          load_evt,
   input logic          center,
   input logic [W-1:0]  cnt,
   input logic [W-1:0]  per_act,
   input logic [W-1:0]  duty_act
);

   logic cnt_wr;
   assign cnt_wr = wr_en && (wr_sel == 2'd2);

   // R8
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == '0));

   // R5
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !cnt_wr) |=> $stable(cnt));

   // R5
   hold_notick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt));

   // R6
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !load_evt) |=> ($stable(per_act) && $stable(duty_act)));

   // R3
   left_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && tick && !wr_en && !center && (per_act != '0)
       && (({1'b0, cnt} + 1'b1) >= {1'b0, per_act})) |=> (cnt == '0));

   // R4
   center_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !wr_en && center && (cnt <= per_act)) |=> (cnt <= per_act));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && tick && !wr_en && (per_act == '0)) |=> (cnt == '0));

endmodule

bind pwm_channel pwm_channel_chk #(.W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .enable   (enable),
   .load_evt (load_evt),
   .center   (shape_act.center),
   .cnt      (cnt),
   .per_act  (per_act),
   .duty_act (duty_act)
);

// File: tb/sim_pwm_channel.sv
`timescale 1ns/1ps
module sim_pwm_channel;

   localparam int W = 8;

   typedef struct {
      logic  lvl;
      string tag;
   } sb_item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_out;

   int n_chk  = 0;
   int n_fail = 0;
   int tdiv   = 1;
   int ph     = 0;
   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   pwm_channel u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pwm_out (pwm_out)
   );

   task automatic check(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: pwm_out=%b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // tick strobe: high once every tdiv cycles
   always @(negedge clk) begin
      tick = (ph == 0);
      ph = (ph + 1) % tdiv;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(pwm_out, it.lvl, it.tag);
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   function automatic logic exp_lvl(int c, int per, int duty, logic pol);
      if (per == 0 || c < duty) return pol;
      return ~pol;
   endfunction

   task automatic push_one(logic l, int div, string tag);
      for (int k = 0; k < div; k++) begin
         sb_item_t it;
         it.lvl = l; it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   task automatic push_wave(int per, int duty, logic pol, logic cen, int div,
                            int nper, string tag);
      if (per == 0) begin
         for (int i = 0; i < 8; i++) push_one(pol, div, tag);
         return;
      end
      for (int p = 0; p < nper; p++) begin
         if (cen) begin
            for (int c = 0; c <= per; c++) push_one(exp_lvl(c, per, duty, pol), div, tag);
            for (int c = per - 1; c >= 1; c--) push_one(exp_lvl(c, per, duty, pol), div, tag);
         end else begin
            for (int c = 0; c < per; c++) push_one(exp_lvl(c, per, duty, pol), div, tag);
         end
      end
   endtask

   // counter write; on return the count is 0
   task automatic restart(int div);
      @(posedge clk); #1;
      tdiv = div; ph = 0;
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'hA5;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic cfg(int per, int duty, logic pol, logic cen);
      wr(2'd3, 8'h00);
      wr(2'd0, W'(per));
      wr(2'd1, W'(duty));
      wr(2'd3, {5'd0, cen, pol, 1'b1});
   endtask

   task automatic drain();
      wait (sb_q.size() == 0);
      @(posedge clk); #1;
   endtask

   task automatic run(int per, int duty, logic pol, logic cen, int div, int nper, string tag);
      cfg(per, duty, pol, cen);
      restart(div);
      push_wave(per, duty, pol, cen, div, nper, tag);
      drain();
   endtask

   initial begin
      #(2_000_000);
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(pwm_out, 1'b0, "R1");

      // R3 left-aligned, R2 polarity low
      run(6, 2, 1'b0, 1'b0, 1, 3, "R3");
      // R2 polarity high
      run(5, 3, 1'b1, 1'b0, 1, 2, "R2");
      // R4 center-aligned
      run(4, 2, 1'b0, 1'b1, 1, 2, "R4");
      run(3, 3, 1'b1, 1'b1, 1, 2, "R4");
      // R5 sparse ticks
      run(4, 1, 1'b1, 1'b0, 3, 2, "R5");
      run(3, 1, 1'b0, 1'b1, 2, 2, "R5");
      // R2 duty above period, duty zero
      run(4, 7, 1'b1, 1'b0, 1, 2, "R2");
      run(4, 0, 1'b1, 1'b0, 1, 2, "R2");
      // R10 zero period
      run(0, 3, 1'b1, 1'b0, 1, 1, "R10");

      // R6 / R11: mid-period change of period and polarity waits for boundary
      cfg(6, 3, 1'b0, 1'b0);
      restart(1);
      push_wave(6, 3, 1'b0, 1'b0, 1, 1, "R6");
      push_wave(4, 3, 1'b1, 1'b0, 1, 2, "R11");
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd4;
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'b0000_0011;
      @(posedge clk); #1;
      wr_en = 1'b0;
      drain();

      // R8: buffered writes while running, then counter write applies them now
      wr(2'd0, 8'd5);
      wr(2'd1, 8'd2);
      restart(1);
      push_wave(5, 2, 1'b1, 1'b0, 1, 2, "R8");
      drain();

      // R9 / R6 / R7: duty buffer write, then disable
      cfg(10, 8, 1'b0, 1'b0);
      restart(1);
      repeat (2) @(posedge clk);
      #1;
      wr(2'd1, 8'd2);
      @(negedge clk);
      check(pwm_out, 1'b0, "R6 duty buffered only");
      wr(2'd3, 8'h00);
      @(negedge clk);
      check(pwm_out, 1'b1, "R9 disable loads duty");
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(pwm_out, 1'b1, "R5 disabled count holds");
      wr(2'd1, 8'd9);
      @(negedge clk);
      check(pwm_out, 1'b0, "R7 direct duty write");
      wr(2'd3, 8'b0000_0010);
      @(negedge clk);
      check(pwm_out, 1'b1, "R11 direct polarity write");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule